// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 16-bit instruction halfword of a 16-register, 32-bit core into the control fields that the execute stage consumes. The two top bits of the halfword pick one of three encodings. A register format carries an 8-bit opcode and two 4-bit register indices. A short-immediate format carries a 2-bit opcode, one register and an 8-bit unsigned constant. A branch format carries a 4-bit condition opcode and a 10-bit halfword offset.

Certain register-format opcodes are followed by a 32-bit extension word that holds a constant or an absolute address. The fetch stage presents the four bytes that follow the halfword, lowest address first, and the decoder assembles them most significant byte first. It reports the instruction length as 2 or 6 bytes. For the offset load and store forms it names the register that acts as the address base, and it flags every encoding outside the defined set. The decoder is purely combinational and holds no state.

Top module: `insn_decoder`

## Requirements
- R1: Bit 15 clear selects the register format, with op_id = insn[15:8]. Bits 15:14 = 10 select the short-immediate format, with op_id = 0x80 + insn[13:12]. Bits 15:14 = 11 select the branch format, with op_id = 0xC0 + insn[13:10].
- R2: In the register format, reg_a = insn[7:4] and reg_b = insn[3:0].
- R3: In the short-immediate format, reg_a = insn[11:8], reg_b = 0 and imm = insn[7:0] zero-extended. All four opcodes are legal: add, subtract, read special register and write special register.
- R4: Register-format opcodes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36 to 0x39 take an extension word, and len_bytes = 6 for them.
- R5: For those opcodes, imm = {ext0, ext1, ext2, ext3}, where ext0 is the byte at the lowest address.
- R6: For offset loads (0x0C, 0x36, 0x38), base_valid = 1 and base_idx = insn[3:0]. For offset stores (0x0D, 0x37, 0x39), base_valid = 1 and base_idx = insn[7:4]. For every other instruction, base_valid = 0 and base_idx = 0.
- R7: In the branch format, opcodes 0 to 9 are legal, imm = insn[9:0] sign-extended and multiplied by 2, and reg_a = reg_b = 0.
- R8: illegal = 1 for register-format opcodes 0x00, 0x0F excluded (0x0F is legal), 0x10 to 0x18 and 0x3A to 0x7F, and for branch opcodes 10 to 15. For these, imm = 0 and len_bytes = 2.
- R9: len_bytes = 2 for every instruction outside the R4 list.
- R10: Register-format instructions outside the R4 list give imm = 0, whatever the extension bytes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 16 | Instruction halfword |
| ext0 | input | 8 | Extension byte at the lowest address |
| ext1 | input | 8 | Extension byte at address +1 |
| ext2 | input | 8 | Extension byte at address +2 |
| ext3 | input | 8 | Extension byte at the highest address |
| op_id | output | 8 | Unified operation code (format in bits 7:6) |
| reg_a | output | 4 | First register index |
| reg_b | output | 4 | Second register index |
| base_idx | output | 4 | Address base register for offset loads and stores |
| base_valid | output | 1 | base_idx is meaningful |
| imm | output | 32 | Decoded immediate or branch byte offset |
| len_bytes | output | 3 | Instruction length, 2 or 6 |
| illegal | output | 1 | Undefined encoding |

## Verification
The decoder has no parameters, so the bench builds it at its fixed widths: a 16-bit halfword, 4-bit register indices and a 32-bit immediate. At that size the bench sweeps all 128 register-format opcodes, all four short-immediate opcodes and all sixteen branch opcodes exhaustively. The sweep covers both offset polarities and the defined/undefined edges at 0x00, 0x0F/0x10, 0x18/0x19 and 0x39/0x3A. Distinct extension byte values expose byte-order swaps. Random halfwords with random extension bytes cover the remaining field combinations.

// File: rtl/insn_decoder.sv
module insn_decoder (
  input  logic [15:0] insn,
  input  logic [7:0]  ext0,
  input  logic [7:0]  ext1,
  input  logic [7:0]  ext2,
  input  logic [7:0]  ext3,
  output logic [7:0]  op_id,
  output logic [3:0]  reg_a,
  output logic [3:0]  reg_b,
  output logic [3:0]  base_idx,
  output logic        base_valid,
  output logic [31:0] imm,
  output logic [2:0]  len_bytes,
  output logic        illegal
);

  localparam logic [2:0] LEN_SHORT = 3'd2;
  localparam logic [2:0] LEN_LONG  = 3'd6;
  localparam logic [3:0] LAST_BRANCH = 4'd9;

  logic       fmt_reg, fmt_imm8, fmt_br;
  logic [6:0] opc;
  logic       reg_ok, reg_ext, br_ok, ld_off, st_off, has_ext;

  assign fmt_reg  = ~insn[15];
  assign fmt_imm8 = insn[15] & ~insn[14];
  assign fmt_br   = insn[15] & insn[14];
  assign opc      = insn[14:8];

  always_comb begin
    reg_ok  = opc inside {[7'h01:7'h0f], [7'h19:7'h39]};
    reg_ext = opc inside {7'h01, 7'h03, 7'h08, 7'h09, 7'h0c, 7'h0d, 7'h1a,
                          7'h1b, 7'h1d, 7'h1f, 7'h20, 7'h22, 7'h24, 7'h30,
                          [7'h36:7'h39]};
    ld_off  = fmt_reg & (opc inside {7'h0c, 7'h36, 7'h38});
    st_off  = fmt_reg & (opc inside {7'h0d, 7'h37, 7'h39});
  end

  assign br_ok   = insn[13:10] <= LAST_BRANCH;
  assign has_ext = fmt_reg & reg_ext;
  assign illegal = (fmt_reg & ~reg_ok) | (fmt_br & ~br_ok);

  assign op_id = fmt_reg  ? insn[15:8] :
                 fmt_imm8 ? {6'b100000, insn[13:12]} :
                            {4'b1100, insn[13:10]};

  assign reg_a = fmt_reg ? insn[7:4] : fmt_imm8 ? insn[11:8] : 4'd0;
  assign reg_b = fmt_reg ? insn[3:0] : 4'd0;

  assign base_valid = ld_off | st_off;
  assign base_idx   = ld_off ? insn[3:0] : st_off ? insn[7:4] : 4'd0;

  assign len_bytes = has_ext ? LEN_LONG : LEN_SHORT;

  always_comb begin
    if (has_ext)
      imm = {ext0, ext1, ext2, ext3};
    else if (fmt_imm8)
      imm = {24'd0, insn[7:0]};
    else if (fmt_br && br_ok)
      imm = {{21{insn[9]}}, insn[9:0], 1'b0};
    else
      imm = 32'd0;
  end

  always_comb begin
    assert_long_only_reg_fmt_R4: assert (len_bytes != LEN_LONG || (!insn[15] && !illegal))
      else $error("long instruction outside the register format");
    assert_illegal_short_R8: assert (!illegal || (len_bytes == LEN_SHORT && imm == 32'd0))
      else $error("illegal encoding with length or immediate set");
    assert_no_regb_upper_R3: assert (!insn[15] || reg_b == 4'd0)
      else $error("reg_b set outside the register format");
    assert_branch_even_R7: assert (!(insn[15] && insn[14]) || imm[0] == 1'b0)
      else $error("odd branch offset");
    assert_base_reg_fmt_R6: assert (!base_valid || (!insn[15] && len_bytes == LEN_LONG))
      else $error("base register reported for a non-offset form");
  end

endmodule

// File: tb/insn_decoder_test.sv
module insn_decoder_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] insn;
  logic [7:0]  ext0, ext1, ext2, ext3;
  logic [7:0]  op_id;
  logic [3:0]  reg_a, reg_b, base_idx;
  logic        base_valid, illegal;
  logic [31:0] imm;
  logic [2:0]  len_bytes;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  insn_decoder uut (
    .insn(insn), .ext0(ext0), .ext1(ext1), .ext2(ext2), .ext3(ext3),
    .op_id(op_id), .reg_a(reg_a), .reg_b(reg_b), .base_idx(base_idx),
    .base_valid(base_valid), .imm(imm), .len_bytes(len_bytes),
    .illegal(illegal)
  );

  function automatic bit ref_ext(input int o);
    case (o)
      'h01, 'h03, 'h08, 'h09, 'h0c, 'h0d, 'h1a, 'h1b, 'h1d, 'h1f,
      'h20, 'h22, 'h24, 'h30, 'h36, 'h37, 'h38, 'h39: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_bad(input int o);
    return (o == 0) || (o >= 'h10 && o <= 'h18) || (o >= 'h3a);
  endfunction

  task automatic cmp(input string what, input string tag, input longint act, input longint exp);
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: insn=%h actual=%0h expected=%0h", tag, what, insn, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] i, input logic [31:0] e);
    logic [7:0]  x_op;
    logic [3:0]  x_a, x_b, x_base;
    logic        x_bv, x_bad;
    logic [31:0] x_imm;
    int          x_len;
    string       rtag, itag, ltag;
    int          o;
    @(posedge clk);
    insn = i; ext0 = e[31:24]; ext1 = e[23:16]; ext2 = e[15:8]; ext3 = e[7:0];
    @(negedge clk);
    vectors++;
    x_a = 0; x_b = 0; x_base = 0; x_bv = 0; x_bad = 0; x_imm = 0; x_len = 2;
    if (!i[15]) begin
      o = int'(i[14:8]);
      x_op = i[15:8];
      x_a = i[7:4]; x_b = i[3:0]; rtag = "R2";
      x_bad = ref_bad(o);
      if (ref_ext(o)) begin
        x_len = 6; x_imm = e; itag = "R5"; ltag = "R4";
      end else begin
        itag = x_bad ? "R8" : "R10"; ltag = x_bad ? "R8" : "R9";
      end
      if (o == 'h0c || o == 'h36 || o == 'h38) begin x_bv = 1; x_base = i[3:0]; end
      if (o == 'h0d || o == 'h37 || o == 'h39) begin x_bv = 1; x_base = i[7:4]; end
    end else if (!i[14]) begin
      x_op = 8'h80 + 8'(i[13:12]);
      x_a = i[11:8]; x_imm = 32'(i[7:0]);
      rtag = "R3"; itag = "R3"; ltag = "R9";
    end else begin
      o = int'(i[13:10]);
      x_op = 8'hc0 + 8'(o);
      rtag = "R7"; ltag = (o > 9) ? "R8" : "R9";
      if (o > 9) begin x_bad = 1; itag = "R8"; end
      else begin
        x_imm = 32'(signed'(i[9:0])) * 2; itag = "R7";
      end
    end
    cmp("op_id", "R1", op_id, x_op);
    cmp("reg_a", rtag, reg_a, x_a);
    cmp("reg_b", rtag, reg_b, x_b);
    cmp("base_idx", "R6", base_idx, x_base);
    cmp("base_valid", "R6", base_valid, x_bv);
    cmp("imm", itag, imm, x_imm);
    cmp("len_bytes", ltag, len_bytes, x_len);
    cmp("illegal", "R8", illegal, x_bad);
  endtask

  initial begin
    insn = 0; ext0 = 0; ext1 = 0; ext2 = 0; ext3 = 0;
    void'($urandom(32'd7741));
    // R5 byte order with distinct bytes
    apply(16'h01a5, 32'h11223344);
    apply(16'h0c37, 32'h8000_00ff);
    // R6 offset polarity
    apply(16'h3712, 32'h0);
    apply(16'h3912, 32'h0);
    // R10 extension bytes ignored for a short op
    apply(16'h0534, 32'hdeadbeef);
    // R1 R2 R4 R8 R9 every register-format opcode
    for (int k = 0; k < 128; k++)
      apply({1'b0, 7'(k), 8'h9c}, 32'hcafe_0001 + 32'(k));
    // R3 all short-immediate opcodes
    for (int k = 0; k < 4; k++) apply({2'b10, 2'(k), 4'hd, 8'hff}, 32'hffffffff);
    // R7 branch opcodes, both offset signs and extremes
    for (int k = 0; k < 16; k++) begin
      apply({2'b11, 4'(k), 10'h1ff}, 32'h0);
      apply({2'b11, 4'(k), 10'h200}, 32'h0);
      apply({2'b11, 4'(k), 10'h3ff}, 32'h0);
    end
    for (int k = 0; k < 3000; k++) apply(16'($urandom), $urandom);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule